// File: doc/BRIEF.md
# ASCII Hex Pixel Frame Receiver

This block sits behind a byte-wide serial receiver (8N1 characters at 115200 baud) and turns a text stream into pixel memory writes. The sender opens a frame with a lower-case `z`, then sends each 24-bit pixel as six hexadecimal characters, most significant digit first. It closes the frame with `!`. Every completed group of six digits becomes one write of the assembled pixel into a pixel memory at the next sequential address.

The frame length is a parameter. A display built from six panels uses 3072 pixels, which the sender transmits as two halves of 1536 pixels each. The block accepts hex digits in either case.

When the closing marker arrives after exactly the configured number of whole pixels, the block raises a one-cycle done pulse. It raises an error flag on malformed input. After an error, it ignores everything until the next start marker.

Top module: `hex_frame_rx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `mem_we`, `frame_done` and `frame_err` are low.
- R2: A `z` character (0x7A) received in any state has these effects: it opens a frame, sets the pixel index to zero, discards any partly received pixel and clears `frame_err`.
- R3: The hex digit characters are 0x30–0x39 (values 0–9), 0x41–0x46 and 0x61–0x66 (values 10–15). The first digit of a pixel lands in bits 23:20 and the sixth digit lands in bits 3:0.
- R4: The sixth digit of a pixel causes a one-cycle `mem_we` in the cycle after that character is accepted. That write carries the assembled pixel on `mem_wdata` and the pixel's index within the frame on `mem_addr`. The first five digits cause no write.
- R5: A `!` character (0x21) received inside a frame closes the frame. If no digits are pending and exactly FRAME_PIXELS pixels were written, it also gives a `frame_done` pulse lasting exactly one cycle.
- R6: A `!` that arrives with one to five digits pending, or after fewer than FRAME_PIXELS pixels, sets `frame_err`, closes the frame and gives no `frame_done`.
- R7: A sixth digit that would complete a pixel beyond FRAME_PIXELS sets `frame_err`, closes the frame and causes no write.
- R8: Inside a frame, any character other than a hex digit, `z` or `!` sets `frame_err` and drops the frame. Later hex digits cause no write until the next `z`.
- R9: Outside a frame, every character other than `z` is ignored: it causes no write, no `frame_done` and no change of `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| mem_we | output | 1 | Pixel memory write strobe |
| mem_addr | output | clog2(FRAME_PIXELS) | Pixel index of the write |
| mem_wdata | output | 24 | Assembled pixel value |
| frame_done | output | 1 | One-cycle pulse on a well-formed end of frame |
| frame_err | output | 1 | Malformed input seen; cleared by the next start marker |

## Verification
The bench runs with a four-pixel frame and uses five kinds of stimulus:

- Every one of the 22 digit characters is repeated six times, so each pixel must equal the digit value times 0x111111. This separates the upper-case, lower-case and decimal conversions from one another.
- Multi-digit pixels with distinct digits in mixed case check digit order and address counting.
- All 256 byte values are swept just after a start marker and again outside a frame. This separates legal digits, markers and junk characters, and shows that idle input leaves both the outputs and the error flag untouched.
- Closing marker variants are sent: after a complete frame, after a partial pixel and after a short frame.
- Two sequences exercise the edges of a frame: an overflowing fifth pixel, and a start marker that arrives in the middle of a pixel.

// File: rtl/hex_frame_rx.sv
module hex_frame_rx #(
  parameter int FRAME_PIXELS = 3072,
  localparam int AW = $clog2(FRAME_PIXELS),
  localparam int CW = $clog2(FRAME_PIXELS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [23:0]   mem_wdata,
  output logic          frame_done,
  output logic          frame_err
);

  logic          in_frame;
  logic [2:0]    dcnt;
  logic [19:0]   acc;
  logic [CW-1:0] cnt;

  wire is_dec   = (rx_data >= 8'h30) && (rx_data <= 8'h39);
  wire is_upper = (rx_data >= 8'h41) && (rx_data <= 8'h46);
  wire is_lower = (rx_data >= 8'h61) && (rx_data <= 8'h66);
  wire is_hex   = is_dec || is_upper || is_lower;
  wire is_open  = rx_data == 8'h7A;
  wire is_close = rx_data == 8'h21;
  wire [3:0] nib = is_dec ? rx_data[3:0] : rx_data[3:0] + 4'd9;
  wire full      = cnt == CW'(FRAME_PIXELS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      dcnt       <= '0;
      acc        <= '0;
      cnt        <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      frame_done <= 1'b0;
      if (rx_valid) begin
        if (is_open) begin
          in_frame  <= 1'b1;
          cnt       <= '0;
          dcnt      <= '0;
          frame_err <= 1'b0;
        end else if (in_frame) begin
          if (is_hex) begin
            if (dcnt == 3'd5) begin
              dcnt <= '0;
              if (full) begin
                frame_err <= 1'b1;
                in_frame  <= 1'b0;
              end else begin
                mem_we    <= 1'b1;
                mem_addr  <= cnt[AW-1:0];
                mem_wdata <= {acc, nib};
                cnt       <= cnt + 1'b1;
              end
            end else begin
              acc  <= {acc[15:0], nib};
              dcnt <= dcnt + 3'd1;
            end
          end else if (is_close) begin
            in_frame <= 1'b0;
            if (dcnt == 3'd0 && full) frame_done <= 1'b1;
            else                      frame_err  <= 1'b1;
          end else begin
            frame_err <= 1'b1;
            in_frame  <= 1'b0;
          end
        end
      end
    end
  end

  // R4
  we_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(mem_addr) < FRAME_PIXELS));

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R6
  done_not_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !frame_err);

  // R2
  open_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && is_open) |=> (!frame_err && !mem_we && !frame_done));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && rx_valid && !is_open) |=> (!mem_we && !frame_done && $stable(frame_err)));

endmodule

// File: tb/sim_hex_frame_rx.sv
`timescale 1ns/1ps
module sim_hex_frame_rx;
  localparam int N = 4;

  logic clk = 1'b0, rst_n = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic mem_we, frame_done, frame_err;
  logic [1:0] mem_addr;
  logic [23:0] mem_wdata;
  int nchk = 0, nfail = 0;
  bit finished = 1'b0;
  logic s_we, s_done, s_err;
  logic [1:0] s_addr;
  logic [23:0] s_data;

  always #2.5 clk = ~clk;

  hex_frame_rx #(.FRAME_PIXELS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .frame_done(frame_done), .frame_err(frame_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    rx_valid = 1'b1;
    rx_data  = c;
    @(negedge clk);
    rx_valid = 1'b0;
    s_we = mem_we; s_addr = mem_addr; s_data = mem_wdata;
    s_done = frame_done; s_err = frame_err;
  endtask

  function automatic logic [7:0] hexch(input int n, input bit lower);
    if (n < 10) return 8'(48 + n);
    return 8'((lower ? 97 : 65) + n - 10);
  endfunction

  function automatic bit is_hex(input int b);
    return (b >= 48 && b <= 57) || (b >= 65 && b <= 70) || (b >= 97 && b <= 102);
  endfunction

  task automatic send_pixel(input logic [23:0] v, input int addr, input bit lower, input bit wr);
    for (int i = 0; i < 6; i++) begin
      send(hexch(int'((v >> (20 - 4 * i)) & 24'hF), lower));
      if (i < 5) chk("R4 no write before sixth digit", s_we, 0);
      else if (wr) begin
        chk("R4 write strobe", s_we, 1);
        chk("R4 write address", s_addr, addr);
        chk("R3 pixel value", s_data, v);
      end else chk("R7 no write", s_we, 0);
    end
  endtask

  task automatic good_frame(input int seed);
    send(8'h7A);
    chk("R2 open clears error", s_err, 0);
    for (int k = 0; k < N; k++)
      send_pixel(24'(32'hA5C3E1 ^ (k * 32'h123457) ^ seed), k, k[0], 1'b1);
    send(8'h21);
    chk("R5 done pulse", s_done, 1);
    chk("R5 no error", s_err, 0);
    @(negedge clk);
    chk("R5 done lasts one cycle", frame_done, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 we in reset", mem_we, 0);
    chk("R1 done in reset", frame_done, 0);
    chk("R1 err in reset", frame_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 we after reset", mem_we, 0);
    chk("R1 err after reset", frame_err, 0);

    good_frame(0);
    good_frame(32'h5A5A5A);

    // R3 digit sweep
    for (int n = 0; n < 16; n++)
      for (int lc = 0; lc < 2; lc++) begin
        send(8'h7A);
        send_pixel(24'(n * 32'h111111), 0, lc[0], 1'b1);
      end

    // R8 byte sweep inside a frame
    for (int b = 0; b < 256; b++) begin
      send(8'h7A);
      send(8'(b));
      chk("R8 no write on single char", s_we, 0);
      chk("R8 error classification", s_err, !(is_hex(b) || b == 8'h7A));
      if (!is_hex(b) && b != 8'h7A) begin
        for (int i = 0; i < 6; i++) begin
          send(8'h46);
          chk("R8 dropped frame writes nothing", s_we, 0);
        end
        chk("R8 error persists", s_err, 1);
      end
    end

    // R9 idle sweep with error clear
    good_frame(7);
    for (int b = 0; b < 256; b++)
      if (b != 8'h7A) begin
        send(8'(b));
        chk("R9 idle no write", s_we, 0);
        chk("R9 idle no done", s_done, 0);
        chk("R9 idle err stays low", s_err, 0);
      end

    // R9 idle sweep with error set
    send(8'h7A);
    send(8'h23);
    chk("R8 junk sets error", s_err, 1);
    for (int b = 0; b < 256; b++)
      if (b != 8'h7A) begin
        send(8'(b));
        chk("R9 idle no write", s_we, 0);
        chk("R9 idle err stays high", s_err, 1);
      end

    // R6 partial pixel
    send(8'h7A);
    send_pixel(24'h102030, 0, 1'b0, 1'b1);
    send(8'h31); send(8'h32); send(8'h33);
    send(8'h21);
    chk("R6 partial gives error", s_err, 1);
    chk("R6 partial gives no done", s_done, 0);

    // R6 short frame
    send(8'h7A);
    send_pixel(24'h0000FF, 0, 1'b0, 1'b1);
    send_pixel(24'hFF0000, 1, 1'b1, 1'b1);
    send(8'h21);
    chk("R6 short gives error", s_err, 1);
    chk("R6 short gives no done", s_done, 0);

    // R7 overflow
    send(8'h7A);
    for (int k = 0; k < N; k++) send_pixel(24'(k + 1), k, 1'b0, 1'b1);
    send_pixel(24'hABCDEF, 0, 1'b0, 1'b0);
    chk("R7 overflow error", s_err, 1);
    send(8'h21);
    chk("R7 no done after overflow", s_done, 0);

    // R2 restart mid-pixel
    send(8'h7A);
    chk("R2 error cleared", s_err, 0);
    send(8'h31); send(8'h32); send(8'h33);
    send(8'h7A);
    send_pixel(24'hABCDEF, 0, 1'b1, 1'b1);
    send_pixel(24'h123456, 1, 1'b0, 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule